// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. An operation request carries the accumulator value, a second operand, the incoming carry, the interrupt-enable-2 bit, the raw opcode byte and a 4-bit operation code. The block returns the result byte and a six-bit condition-flag vector. It also returns a write-enable that tells the caller whether to update the accumulator, and a second byte for the nibble-rotate operation, which rewrites a memory location.

Requests enter on a valid/ready port and results leave on a valid/ready port, with one register slice between them. A request is taken on a rising edge while `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or is being emptied in the same cycle. A result waiting with `out_ready` low keeps every output field unchanged. A small combinational decoder also picks the register-operand index out of the opcode byte. This index is available in the same cycle, so the caller can read its register file before the request is issued.

Flag vector bit positions: 5 sign, 4 zero, 3 half-carry, 2 parity/overflow, 1 subtract, 0 carry. Operation codes: ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, AND=5, OR=6, XOR=7, INC=8, DEC=9, NEG=10, RRD=11, XFER=12.

Top module: `alu8_core`

## Requirements
- R1: `in_ready` equals (not `out_valid`) or `out_ready`. A request accepted on an edge appears at the outputs with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R2: ADD (0) gives A+B and ADC (1) gives A+B+carry-in. Half-carry is the carry out of bit 3, P/V is signed overflow, carry is the carry out of bit 7, and subtract is cleared.
- R3: SUB (2) gives A−B and SBC (3) gives A−B−carry-in. CMP (4) gives the flags of A−B with write-enable low. All three set subtract, take half-carry from the borrow out of bit 3 and carry from the borrow out of bit 7, and set P/V on signed overflow.
- R4: AND (5), OR (6) and XOR (7) clear carry and subtract and set P/V to the even parity of the result. Half-carry is set for AND and cleared for OR and XOR.
- R5: INC (8) gives A+1 and clears subtract, with P/V set only for A=0x7F. DEC (9) gives A−1 and sets subtract, with P/V set only for A=0x80. Both pass the carry-in through unchanged, and half-carry follows the bit-3 carry or borrow.
- R6: NEG (10) gives 0−A in 8 bits and sets subtract. Carry is set exactly when A≠0, P/V is set only for A=0x80, and half-carry is the borrow out of bit 3.
- R7: RRD (11) returns {A[7:4], B[3:0]} as result and {A[3:0], B[7:4]} as the memory byte. Half-carry and subtract are cleared, P/V is the even parity of the result, and carry passes through. The memory byte is zero for every other operation.
- R8: XFER (12) returns B as result, clears half-carry and subtract, loads P/V from the interrupt-enable-2 input and passes carry through.
- R9: For every operation, sign equals result bit 7 and zero is set exactly when the result is 0. Write-enable is high for codes 0–12 except CMP.
- R10: `src_idx` is opcode bits [5:3] when `in_op` is INC or DEC, and opcode bits [2:0] otherwise, in the same cycle.
- R11: During reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_opcode | input | 8 | Raw opcode byte for the index decoder |
| in_acc | input | 8 | Accumulator value |
| in_opnd | input | 8 | Second operand / memory byte |
| in_carry | input | 1 | Current carry flag |
| in_ie | input | 1 | Current interrupt-enable-2 bit |
| src_idx | output | 3 | Decoded register-operand index (combinational) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | New accumulator value (difference for CMP) |
| out_mem | output | 8 | New memory byte for RRD, else zero |
| out_flags | output | 6 | S,Z,H,P/V,N,C at bits 5..0 |
| out_wb | output | 1 | Accumulator write-enable |

## Verification
A result is due on the outputs one clock edge after the edge that accepted its request. `src_idx` and `in_ready` are due in the same cycle as the inputs that drive them. The bench changes inputs just after the falling edge and samples about 1 ns later, still before the next rising edge. It pushes the expected result of each accepted request into a queue, and it pops and compares that result only in a cycle where `out_valid` and `out_ready` are both high. Random stalls on `out_ready` and gaps on `in_valid` make results wait in the slice, so the hold rule is checked against the same queued entry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_ADC  = 4'd1,
    ALU_SUB  = 4'd2,
    ALU_SBC  = 4'd3,
    ALU_CMP  = 4'd4,
    ALU_AND  = 4'd5,
    ALU_OR   = 4'd6,
    ALU_XOR  = 4'd7,
    ALU_INC  = 4'd8,
    ALU_DEC  = 4'd9,
    ALU_NEG  = 4'd10,
    ALU_RRD  = 4'd11,
    ALU_XFER = 4'd12
  } alu_op_e;

  localparam int OP_W   = 4;
  localparam int FLAG_W = 6;

  typedef struct packed {
    logic s;
    logic z;
    logic h;
    logic pv;
    logic n;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu8_regsel.sv
module alu8_regsel #(
  parameter int OPC_W = 8,
  parameter int IDX_W = 3
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             upper,
  output logic [IDX_W-1:0] idx
);
  localparam int HI_LSB = IDX_W;
  assign idx = upper ? opcode[HI_LSB +: IDX_W] : opcode[IDX_W-1:0];
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         co,
  output logic         hc,
  output logic         ov
);
  localparam int HW = W / 2;

  logic [W:0]  full;
  logic [HW:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
      half = {1'b0, x[HW-1:0]} - {1'b0, y[HW-1:0]} - {{HW{1'b0}}, ci};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      half = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, ci};
    end
  end

  assign r  = full[W-1:0];
  assign co = full[W];
  assign hc = half[HW];
  assign ov = sub ? ((x[W-1] ^ y[W-1]) & (r[W-1] ^ x[W-1]))
                  : ((x[W-1] ~^ y[W-1]) & (r[W-1] ^ x[W-1]));
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
  parameter int W = 8
) (
  input  logic [1:0]   kind,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r_log,
  output logic [W-1:0] r_rot,
  output logic [W-1:0] m_rot
);
  localparam int HW = W / 2;

  always_comb begin
    unique case (kind)
      2'd0:    r_log = a & b;
      2'd1:    r_log = a | b;
      default: r_log = a ^ b;
    endcase
  end

  assign r_rot = {a[W-1:HW], b[HW-1:0]};
  assign m_rot = {a[HW-1:0], b[W-1:HW]};
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W     = 8,
  parameter int OPC_W = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [W-1:0]      in_acc,
  input  logic [W-1:0]      in_opnd,
  input  logic              in_carry,
  input  logic              in_ie,
  output logic [IDX_W-1:0]  src_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result,
  output logic [W-1:0]      out_mem,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_wb
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  alu_op_e op;
  assign op = alu_op_e'(in_op);

  alu8_regsel #(.OPC_W(OPC_W), .IDX_W(IDX_W)) u_sel (
    .opcode (in_opcode),
    .upper  (op == ALU_INC || op == ALU_DEC),
    .idx    (src_idx)
  );

  logic [W-1:0] as_x, as_y, as_r;
  logic         as_ci, as_sub, as_co, as_hc, as_ov;

  always_comb begin
    as_x   = in_acc;
    as_y   = in_opnd;
    as_ci  = 1'b0;
    as_sub = 1'b0;
    unique case (op)
      ALU_ADC:                   as_ci = in_carry;
      ALU_SUB, ALU_CMP:          as_sub = 1'b1;
      ALU_SBC: begin             as_sub = 1'b1; as_ci = in_carry; end
      ALU_INC:                   as_y = ONE;
      ALU_DEC: begin             as_sub = 1'b1; as_y = ONE; end
      ALU_NEG: begin             as_sub = 1'b1; as_x = ZERO; as_y = in_acc; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_as (
    .x (as_x), .y (as_y), .ci (as_ci), .sub (as_sub),
    .r (as_r), .co (as_co), .hc (as_hc), .ov (as_ov)
  );

  logic [1:0]   bo_kind;
  logic [W-1:0] bo_log, bo_rot, bo_mem;

  assign bo_kind = (op == ALU_AND) ? 2'd0 : (op == ALU_OR) ? 2'd1 : 2'd2;

  alu8_bitops #(.W(W)) u_bo (
    .kind (bo_kind), .a (in_acc), .b (in_opnd),
    .r_log (bo_log), .r_rot (bo_rot), .m_rot (bo_mem)
  );

  logic [W-1:0] nx_res, nx_mem;
  flags_t       nx_fl;
  logic         nx_wb;

  always_comb begin
    nx_res = ZERO;
    nx_mem = ZERO;
    nx_wb  = 1'b1;
    nx_fl  = '0;
    unique case (op)
      ALU_ADD, ALU_ADC, ALU_SUB, ALU_SBC, ALU_CMP, ALU_NEG: begin
        nx_res   = as_r;
        nx_fl.h  = as_hc;
        nx_fl.pv = as_ov;
        nx_fl.n  = as_sub;
        nx_fl.c  = as_co;
        nx_wb    = (op != ALU_CMP);
      end
      ALU_INC, ALU_DEC: begin
        nx_res   = as_r;
        nx_fl.h  = as_hc;
        nx_fl.pv = as_ov;
        nx_fl.n  = as_sub;
        nx_fl.c  = in_carry;
      end
      ALU_AND, ALU_OR, ALU_XOR: begin
        nx_res   = bo_log;
        nx_fl.h  = (op == ALU_AND);
        nx_fl.pv = ~^bo_log;
      end
      ALU_RRD: begin
        nx_res   = bo_rot;
        nx_mem   = bo_mem;
        nx_fl.pv = ~^bo_rot;
        nx_fl.c  = in_carry;
      end
      ALU_XFER: begin
        nx_res   = in_opnd;
        nx_fl.pv = in_ie;
        nx_fl.c  = in_carry;
      end
      default: nx_wb = 1'b0;
    endcase
    nx_fl.s = nx_res[W-1];
    nx_fl.z = (nx_res == ZERO);
  end

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= ZERO;
      out_mem    <= ZERO;
      out_flags  <= '0;
      out_wb     <= 1'b0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_result <= nx_res;
        out_mem    <= nx_mem;
        out_flags  <= nx_fl;
        out_wb     <= nx_wb;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int W     = 8,
  parameter int OPC_W = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [OPC_W-1:0] in_opcode,
  input logic [W-1:0]     in_acc,
  input logic [W-1:0]     in_opnd,
  input logic             in_carry,
  input logic             in_ie,
  input logic [IDX_W-1:0] src_idx,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_result,
  input logic [W-1:0]     out_mem,
  input logic [5:0]       out_flags,
  input logic             out_wb
);
  logic fire;
  assign fire = in_valid && in_ready;

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_flags) && $stable(out_wb)));

  a_r3_cmp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 4'd4) |=> (!out_wb && out_flags[1]));

  a_r4_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == 4'd6 || in_op == 4'd7)) |=> (out_flags[3:0] & 4'b1011) == 4'b0000);

  a_r5_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == 4'd8 || in_op == 4'd9)) |=> out_flags[0] == $past(in_carry));

  a_r6_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 4'd10 && in_acc == '0) |=> (out_result == '0 && !out_flags[0] && !out_flags[2]));

  a_r9_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[4] == (out_result == '0) && out_flags[5] == out_result[W-1]));

  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind alu8_core alu8_core_chk #(.W(W), .OPC_W(OPC_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = 4'd0;
  logic [7:0] in_opcode = 8'd0;
  logic [7:0] in_acc = 8'd0;
  logic [7:0] in_opnd = 8'd0;
  logic       in_carry = 1'b0;
  logic       in_ie = 1'b0;
  logic [2:0] src_idx;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [7:0] out_mem;
  logic [5:0] out_flags;
  logic       out_wb;

  always #10 clk = ~clk;

  alu8_core dut (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int q_op[$], q_res[$], q_mem[$], q_fl[$], q_wb[$];

  function automatic int sg(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int par_even(int v);
    int cnt = 0;
    for (int i = 0; i < 8; i++) cnt += (v >> i) & 1;
    return (cnt % 2 == 0) ? 1 : 0;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1:    return "R2";
      2, 3, 4: return "R3";
      5, 6, 7: return "R4";
      8, 9:    return "R5";
      10:      return "R6";
      11:      return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model(input int op, input int a, input int b, input int ci, input int ie,
                       output int res, output int mem, output int fl, output int wb);
    int t, sv, h, v, n, c;
    res = 0; mem = 0; wb = 1; h = 0; v = 0; n = 0; c = 0;
    case (op)
      0, 1: begin
        int cc = (op == 1) ? ci : 0;
        t = a + b + cc; res = t & 255; c = (t > 255);
        h = (((a & 15) + (b & 15) + cc) > 15);
        sv = sg(a) + sg(b) + cc; v = (sv > 127 || sv < -128);
      end
      2, 3, 4: begin
        int cc = (op == 3) ? ci : 0;
        t = a - b - cc; res = t & 255; c = (t < 0);
        h = (((a & 15) - (b & 15) - cc) < 0);
        sv = sg(a) - sg(b) - cc; v = (sv > 127 || sv < -128);
        n = 1; wb = (op != 4);
      end
      5, 6, 7: begin
        res = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
        h = (op == 5); v = par_even(res);
      end
      8: begin res = (a + 1) & 255; h = ((a & 15) == 15); v = (a == 127); c = ci; end
      9: begin res = (a - 1) & 255; h = ((a & 15) == 0); v = (a == 128); n = 1; c = ci; end
      10: begin res = (256 - a) & 255; h = ((a & 15) != 0); v = (a == 128); n = 1; c = (a != 0); end
      11: begin
        res = (a & 240) | (b & 15); mem = ((a & 15) << 4) | (b >> 4);
        v = par_even(res); c = ci;
      end
      default: begin res = b; v = ie; c = ci; end
    endcase
    fl = ((res >= 128) << 5) | ((res == 0) << 4) | (h << 3) | (v << 2) | (n << 1) | c;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // sampled 1 ns after the falling edge, with this cycle's inputs settled
  task automatic sample();
    check("R1", "out_valid", int'(out_valid), (q_op.size() > 0) ? 1 : 0);
    check("R1", "in_ready", int'(in_ready), (!out_valid || out_ready) ? 1 : 0);
    if (out_valid && out_ready && q_op.size() > 0) begin
      int op = q_op.pop_front();
      int r = q_res.pop_front();
      int m = q_mem.pop_front();
      int f = q_fl.pop_front();
      int w = q_wb.pop_front();
      check(tag_of(op), "result", int'(out_result), r);
      check(tag_of(op), "flags", int'(out_flags), f);
      check("R9", "sign/zero", int'(out_flags[5:4]), (f >> 4) & 3);
      check("R9", "wb", int'(out_wb), w);
      check("R7", "mem byte", int'(out_mem), m);
    end
    if (in_valid) begin
      int up = (in_op == 4'd8 || in_op == 4'd9);
      check("R10", "src_idx", int'(src_idx), up ? int'(in_opcode[5:3]) : int'(in_opcode[2:0]));
    end
  endtask

  task automatic apply(input int op, input int a, input int b, input int ci, input int ie,
                       input bit stall);
    bit fired = 0;
    while (!fired) begin
      @(negedge clk);
      out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      in_valid  = 1'b1;
      in_op     = op[3:0];
      in_acc    = a[7:0];
      in_opnd   = b[7:0];
      in_carry  = ci[0];
      in_ie     = ie[0];
      in_opcode = 8'($urandom);
      #1;
      sample();
      if (in_ready) begin
        int r, m, f, w;
        model(op, a, b, ci, ie, r, m, f, w);
        q_op.push_back(op); q_res.push_back(r); q_mem.push_back(m);
        q_fl.push_back(f); q_wb.push_back(w);
        fired = 1;
      end
    end
  endtask

  task automatic idle(input bit rdy);
    @(negedge clk);
    out_ready = rdy;
    in_valid  = 1'b0;
    #1;
    sample();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11", "out_valid in reset", int'(out_valid), 0);
    check("R11", "in_ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    apply(0, 8'h7F, 8'h01, 0, 0, 0);   // R2 signed overflow, half carry
    apply(1, 8'hFF, 8'h00, 1, 0, 0);   // R2 carry-in wraps to zero
    apply(2, 8'h00, 8'h01, 0, 0, 0);   // R3 borrow
    apply(3, 8'h80, 8'h00, 1, 0, 0);   // R3 overflow via carry-in
    apply(4, 8'h42, 8'h42, 1, 0, 0);   // R3 compare equal, no writeback
    apply(5, 8'hF0, 8'h3C, 1, 0, 0);   // R4
    apply(6, 8'h00, 8'h00, 1, 0, 0);   // R4 zero, even parity
    apply(7, 8'hFF, 8'h01, 1, 0, 0);   // R4 odd parity
    apply(8, 8'h7F, 8'h00, 1, 0, 0);   // R5 overflow, carry kept
    apply(8, 8'hFF, 8'h00, 0, 0, 0);   // R5 wrap, carry kept clear
    apply(9, 8'h80, 8'h00, 1, 0, 0);   // R5 overflow
    apply(9, 8'h00, 8'h00, 0, 0, 0);   // R5 wrap
    apply(10, 8'h00, 8'h00, 1, 0, 0);  // R6 zero: carry clear
    apply(10, 8'h80, 8'h00, 0, 0, 0);  // R6 overflow
    apply(10, 8'h01, 8'h00, 0, 0, 0);  // R6
    apply(11, 8'h12, 8'h34, 1, 0, 0);  // R7
    apply(12, 8'h00, 8'h9A, 0, 1, 0);  // R8 ie=1
    apply(12, 8'hFF, 8'h00, 1, 0, 0);  // R8 ie=0
    idle(1'b1);

    for (int k = 0; k < 600; k++) begin
      if (($urandom % 5) == 0) idle(($urandom % 2) == 0);
      apply(int'($urandom % 13), int'($urandom % 256), int'($urandom % 256),
            int'($urandom % 2), int'($urandom % 2), 1);
    end
    repeat (4) idle(1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule